// File: doc/BRIEF.md
# Controller FSM with Test-State Injection

This block is a small control state machine whose state register has two test controls. In normal operation it steps through four reachable states. It reacts to two primary inputs and two status inputs, and drives a four-bit control word. In test operation the state register can be loaded from an injection generator instead of the next-state logic. The generator supplies the state encodings that no sequence of normal transitions can reach from reset. A test pattern combines a primary-input value, a status-input value and a state value. With injection, a combinational pattern whose state part is one of those unreachable codes can still be applied to the unchanged next-state and output logic.

A separate hold pin freezes the state register. A state that took several cycles to set up can then be kept while several input combinations are applied against it. The register contents are always visible on an observation port, so the captured next state can be read out directly. When both test pins are low, the block behaves cycle for cycle like the plain controller.

Top module: `fsi_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) loads the state register with 3'b000 and clears the injection index to 0, whatever the values of `test_mode_i` and `hold_i`.
- R2: With `test_mode_i`=0 and `hold_i`=0, the next state follows this table. From 000: go to 001 if `pi_i[0]`, else stay. From 001: go to 011. From 011: go to 000 if `pi_i[1]`, else 010 if `st_i[0]`, else stay. From 010: go to 000.
- R3: The control output `co_o` is combinational. It is 4'b0001 in state 000, 4'b0010 in 001, {`st_i[1]`,3'b100} in 011 and 4'b1000 in 010.
- R4: With `test_mode_i`=1 and `hold_i`=0, the state register loads the injection code at the current index, not the next-state value.
- R5: The injection codes are the unreachable encodings in ascending order: index 0..3 gives 100, 101, 110, 111. The index advances by one, wrapping, on every non-reset edge where `test_mode_i`=1, including edges where `hold_i`=1.
- R6: With `hold_i`=1 and no reset, the state register keeps its value, whatever the value of `test_mode_i`.
- R7: `state_obs_o` always equals the state register contents.
- R8: With `test_mode_i` held at 0 from reset on, the state never takes a code with bit 2 set.
- R9: In an unreachable state (bit 2 set), the normal next state is 000 and `co_o` is {state[1:0], `pi_i`}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pi_i | input | 2 | Primary inputs ([0] start, [1] abort) |
| st_i | input | 2 | Status inputs ([0] finished, [1] flag) |
| test_mode_i | input | 1 | 1 selects the injection generator as state source |
| hold_i | input | 1 | 1 freezes the state register |
| co_o | output | 4 | Control outputs |
| state_obs_o | output | 3 | State register observation |

## Verification
The hardest situation to reach is an unreachable state that then runs through the unchanged next-state logic. This needs injection, then a release of the mode pin, and the generator index depends on how many mode-high cycles came before. A second hard case is hold combined with mode high: the index keeps advancing while the state stays frozen, so the code injected after the hold is released is not the one that was next before it. Directed sequences set up both cases with known index values. A long random run with rare resets and mixed mode/hold traffic then compares every cycle against a reference model that tracks both state and index.

// File: rtl/fsi_pkg.sv
package fsi_pkg;
    localparam int SW     = 3;
    localparam int PIW    = 2;
    localparam int STW    = 2;
    localparam int COW    = 4;
    localparam int NREACH = 4;
    localparam int NINJ   = (2 ** SW) - NREACH;
    localparam int IDXW   = $clog2(NINJ);

    typedef logic [SW-1:0]   state_t;
    typedef logic [IDXW-1:0] idx_t;

    localparam state_t S_IDLE = 3'b000;
    localparam state_t S_LOAD = 3'b001;
    localparam state_t S_RUN  = 3'b011;
    localparam state_t S_DONE = 3'b010;

    function automatic logic is_reach(state_t s);
        return (s == S_IDLE) || (s == S_LOAD) || (s == S_RUN) || (s == S_DONE);
    endfunction

    // k-th encoding (ascending) that normal transitions never produce
    function automatic state_t inj_code(idx_t k);
        int     seen;
        state_t r;
        seen = 0;
        r    = S_IDLE;
        for (int c = 0; c < 2 ** SW; c++) begin
            if (!is_reach(state_t'(c))) begin
                if (seen == int'(k)) r = state_t'(c);
                seen++;
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/fsi_next_logic.sv
module fsi_next_logic
    import fsi_pkg::*;
(
    input  state_t             cur_i,
    input  logic [PIW-1:0]     pi_i,
    input  logic [STW-1:0]     st_i,
    output state_t             nxt_o,
    output logic [COW-1:0]     co_o
);
    always_comb begin
        nxt_o = S_IDLE;
        co_o  = '0;
        case (cur_i)
            S_IDLE: begin
                nxt_o = pi_i[0] ? S_LOAD : S_IDLE;
                co_o  = 4'b0001;
            end
            S_LOAD: begin
                nxt_o = S_RUN;
                co_o  = 4'b0010;
            end
            S_RUN: begin
                if (pi_i[1])      nxt_o = S_IDLE;
                else if (st_i[0]) nxt_o = S_DONE;
                else              nxt_o = S_RUN;
                co_o = {st_i[1], 3'b100};
            end
            S_DONE: begin
                nxt_o = S_IDLE;
                co_o  = 4'b1000;
            end
            default: begin
                nxt_o = S_IDLE;
                co_o  = {cur_i[1:0], pi_i};
            end
        endcase
    end
endmodule

// File: rtl/fsi_inject_gen.sv
module fsi_inject_gen
    import fsi_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   adv_i,
    output state_t code_o
);
    typedef struct packed {
        idx_t idx;
    } gen_t;

    gen_t gen_d, gen_q;

    always_comb begin
        gen_d = gen_q;
        if (rst)        gen_d.idx = '0;
        else if (adv_i) gen_d.idx = gen_q.idx + idx_t'(1);
    end

    always_ff @(posedge clk) begin
        gen_q <= gen_d;
    end

    assign code_o = inj_code(gen_q.idx);
endmodule

// File: rtl/fsi_ctrl.sv
module fsi_ctrl
    import fsi_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [PIW-1:0]   pi_i,
    input  logic [STW-1:0]   st_i,
    input  logic             test_mode_i,
    input  logic             hold_i,
    output logic [COW-1:0]   co_o,
    output logic [SW-1:0]    state_obs_o
);
    typedef struct packed {
        state_t state;
    } ctl_t;

    ctl_t   ctl_d, ctl_q;
    state_t nxt;
    state_t inj;

    fsi_next_logic u_next (
        .cur_i (ctl_q.state),
        .pi_i  (pi_i),
        .st_i  (st_i),
        .nxt_o (nxt),
        .co_o  (co_o)
    );

    fsi_inject_gen u_inj (
        .clk    (clk),
        .rst    (rst),
        .adv_i  (test_mode_i),
        .code_o (inj)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (rst)              ctl_d.state = S_IDLE;
        else if (hold_i)      ctl_d.state = ctl_q.state;
        else if (test_mode_i) ctl_d.state = inj;
        else                  ctl_d.state = nxt;
    end

    always_ff @(posedge clk) begin
        ctl_q <= ctl_d;
    end

    assign state_obs_o = ctl_q.state;
endmodule

// File: rtl/fsi_ctrl_chk.sv
module fsi_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       mode,
    input logic       hold,
    input logic [2:0] obs
);
    // R1
    a_r1_reset_idle: assert property (@(posedge clk) rst |=> obs == 3'b000);
    // R6
    a_r6_hold_keeps: assert property (@(posedge clk) disable iff (rst)
        hold |=> obs == $past(obs));
    // R4
    a_r4_inject_unreach: assert property (@(posedge clk) disable iff (rst)
        (mode && !hold) |=> obs[2]);
    // R8
    a_r8_normal_closed: assert property (@(posedge clk) disable iff (rst)
        (!mode && !obs[2]) |=> !obs[2]);
    // R9
    a_r9_unreach_exit: assert property (@(posedge clk) disable iff (rst)
        (!mode && !hold && obs[2]) |=> obs == 3'b000);
endmodule

bind fsi_ctrl fsi_ctrl_chk chk_i (
    .clk  (clk),
    .rst  (rst),
    .mode (test_mode_i),
    .hold (hold_i),
    .obs  (state_obs_o)
);

// File: tb/fsi_ctrl_tb_top.sv
module fsi_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] pi  = '0;
    logic [1:0] st  = '0;
    logic       mode = 1'b0;
    logic       hold = 1'b0;
    logic [3:0] co;
    logic [2:0] obs;

    int checks = 0;
    int errors = 0;

    logic [2:0] m_state = 3'b000;
    logic [1:0] m_idx   = 2'd0;

    always #10 clk = ~clk;

    fsi_ctrl dut_i (
        .clk(clk), .rst(rst), .pi_i(pi), .st_i(st),
        .test_mode_i(mode), .hold_i(hold), .co_o(co), .state_obs_o(obs)
    );

    function automatic logic [2:0] ref_ns(logic [2:0] s, logic [1:0] p, logic [1:0] t);
        case (s)
            3'b000:  return p[0] ? 3'b001 : 3'b000;
            3'b001:  return 3'b011;
            3'b011:  return p[1] ? 3'b000 : (t[0] ? 3'b010 : 3'b011);
            default: return 3'b000;
        endcase
    endfunction

    function automatic logic [3:0] ref_co(logic [2:0] s, logic [1:0] p, logic [1:0] t);
        case (s)
            3'b000:  return 4'b0001;
            3'b001:  return 4'b0010;
            3'b011:  return {t[1], 3'b100};
            3'b010:  return 4'b1000;
            default: return {s[1:0], p};
        endcase
    endfunction

    function automatic logic [2:0] ref_inj(logic [1:0] k);
        return {1'b1, k};
    endfunction

    task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(logic r, logic [1:0] p, logic [1:0] t, logic m, logic h, string tag);
        logic [2:0] code;
        @(negedge clk);
        rst = r; pi = p; st = t; mode = m; hold = h;
        #1;
        chk(m_state[2] ? "R9 co" : "R3 co", co, ref_co(m_state, p, t));
        @(posedge clk);
        code = ref_inj(m_idx);
        if (r) begin
            m_state = 3'b000; m_idx = 2'd0;
        end else begin
            if (m) m_idx = m_idx + 2'd1;
            if (!h) m_state = m ? code : ref_ns(m_state, p, t);
        end
        #1;
        chk({tag, " R7 obs"}, {1'b0, obs}, {1'b0, m_state});
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd5150));
        // R1: reset with both test pins high
        cyc(1, 2'b11, 2'b11, 1, 1, "R1");
        cyc(1, 2'b00, 2'b00, 0, 0, "R1");
        chk("R1 reset obs", {1'b0, obs}, 4'b0000);
        // R2: full walk and abort
        cyc(0, 2'b00, 2'b00, 0, 0, "R2");
        cyc(0, 2'b01, 2'b00, 0, 0, "R2");
        cyc(0, 2'b00, 2'b00, 0, 0, "R2");
        cyc(0, 2'b00, 2'b10, 0, 0, "R2");
        cyc(0, 2'b00, 2'b01, 0, 0, "R2");
        cyc(0, 2'b00, 2'b00, 0, 0, "R2");
        cyc(0, 2'b01, 2'b00, 0, 0, "R2");
        cyc(0, 2'b00, 2'b00, 0, 0, "R2");
        cyc(0, 2'b10, 2'b01, 0, 0, "R2");
        // R4/R5: injection sequence with wrap
        for (int i = 0; i < 6; i++) cyc(0, 2'(i), 2'b00, 1, 0, "R4 R5");
        // R6: hold with mode high (index still advances) and with mode low
        cyc(0, 2'b11, 2'b11, 1, 1, "R6 R5");
        cyc(0, 2'b01, 2'b01, 0, 1, "R6");
        cyc(0, 2'b00, 2'b00, 1, 0, "R5 after hold");
        // R9: release from unreachable state
        cyc(0, 2'b10, 2'b00, 0, 0, "R9");
        cyc(0, 2'b00, 2'b00, 1, 0, "R4");
        cyc(0, 2'b01, 2'b11, 0, 1, "R6 R9");
        cyc(0, 2'b11, 2'b01, 0, 0, "R9");
        // R1: reset mid-injection clears index
        cyc(0, 2'b00, 2'b00, 1, 0, "R5");
        cyc(1, 2'b00, 2'b00, 1, 0, "R1");
        cyc(0, 2'b00, 2'b00, 1, 0, "R1 index cleared");
        chk("R1 index cleared", {1'b0, obs}, 4'b0100);
        // R8: normal mode only from reset
        cyc(1, 2'b00, 2'b00, 0, 0, "R8");
        for (int i = 0; i < 300; i++) begin
            cyc(0, 2'($urandom), 2'($urandom), 0, ($urandom % 4) == 0, "R8");
            chk("R8 bit2 clear", {3'b000, obs[2]}, 4'b0000);
        end
        // mixed random traffic
        for (int i = 0; i < 3000; i++) begin
            cyc(($urandom % 40) == 0, 2'($urandom), 2'($urandom),
                ($urandom % 4) == 0, ($urandom % 4) == 0, "R2 R4 R6 mix");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule